// File: doc/BRIEF.md
# Phase-Frequency Detector with Direction Control

This block is the digital heart of a phase-locked frequency synthesiser. It watches two pulse trains, one from the feedback divider that follows the oscillator and one from the reference divider. It turns the time between their rising edges into pump-up and pump-down commands for an external charge pump. Each command is held by its own flag. A rising edge on one input sets that input's flag. Once both flags are set, a short, fixed clear delay runs and then drops both flags together. The pulse on the leading side is therefore as long as the phase error plus the clear delay. The pulse on the lagging side lasts only the clear delay. Because both sides always produce at least a minimum pulse, the detector has no dead zone around zero phase error.

A static direction input sets the sense of the loop. It also swaps which of the two monitor outputs carries the feedback-divider pulses and which carries the reference pulses, so that an external detector wired to those outputs is reversed in the same way. A detector enable forces the pump commands idle. A monitor enable gates both monitor outputs to low. A 2-bit gain selection is decoded into a current-multiplier code counted in half units. In a system where these control inputs are meant to float, tie them high: that is their intended default.

Top module: `pfd_dirctl`

## Requirements
- R1: With `dir_i` high and the feedback edge leading the reference edge by d cycles, `dn_o` is high for d+RST_DLY cycles and `up_o` is high for RST_DLY cycles.
- R2: With `dir_i` high and the reference edge leading the feedback edge by d cycles, `up_o` is high for d+RST_DLY cycles and `dn_o` is high for RST_DLY cycles.
- R3: With `dir_i` low, the roles in R1 and R2 are swapped: a leading feedback edge produces the long `up_o` pulse, and a leading reference edge produces the long `dn_o` pulse.
- R4: When both edges arrive in the same cycle, `up_o` and `dn_o` each pulse high for exactly RST_DLY cycles, at the same time, so there is no dead zone.
- R5: `up_o` and `dn_o` are never high together for more than RST_DLY consecutive cycles.
- R6: With `dir_i` high and the feedback train faster than the reference, `dn_o` is high for more cycles than `up_o` over a window. With `dir_i` low, `up_o` is high for more cycles.
- R7: While `pd_en_i` is low, `up_o` and `dn_o` are low from the next clock edge on, and input edges are ignored. Normal pulses resume after `pd_en_i` returns high.
- R8: With `dir_i` high and `mon_en_i` high, `mon_a_o` follows `rf_div_i` and `mon_b_o` follows `ref_div_i`, two cycles late.
- R9: With `dir_i` low and `mon_en_i` high, `mon_a_o` follows `ref_div_i` and `mon_b_o` follows `rf_div_i`.
- R10: While `mon_en_i` is low, both monitor outputs are low from the next clock edge.
- R11: `gain_code_o` gives the multiplier in units of 0.5, one cycle after `gain_sel_i`: 2'b00 gives 2 (x1.0), 2'b01 gives 3 (x1.5), 2'b10 gives 5 (x2.5), 2'b11 gives 8 (x4.0).
- R12: While `rst` is high, `up_o`, `dn_o`, `mon_a_o`, `mon_b_o` and `gain_code_o` are all zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_div_i | input | 1 | Pulse train from the feedback (oscillator) divider |
| ref_div_i | input | 1 | Pulse train from the reference divider |
| dir_i | input | 1 | Loop sense and monitor swap (tie high by default) |
| pd_en_i | input | 1 | Detector enable; low idles the pump commands (tie high by default) |
| mon_en_i | input | 1 | Monitor output enable (tie high by default) |
| gain_sel_i | input | 2 | Charge-pump gain selection (tie high by default) |
| up_o | output | 1 | Pump source command |
| dn_o | output | 1 | Pump sink command |
| mon_a_o | output | 1 | Monitor A: feedback pulses when dir high, reference pulses when low |
| mon_b_o | output | 1 | Monitor B: the other pulse train |
| gain_code_o | output | 4 | Current multiplier in units of 0.5 |

## Verification
A flag that fails to clear, or a clear counter stuck at the wrong value, shows up within the same edge pair: both commands stay high past RST_DLY cycles, or the measured pulse widths stray from d+RST_DLY and RST_DLY. If the direction steering is wrong, the long pulse lands on the wrong output in the first lead/lag scenario, and the monitor levels come out swapped two cycles after the inputs settle. Faults in the enable gating or the gain decode are visible at the outputs one cycle after the control input changes.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  localparam int GAIN_W = 4;

  typedef enum logic [1:0] {
    GS_X1P0 = 2'b00,
    GS_X1P5 = 2'b01,
    GS_X2P5 = 2'b10,
    GS_X4P0 = 2'b11
  } gain_sel_e;

  // multiplier expressed in half units
  function automatic logic [GAIN_W-1:0] gain_to_code(input gain_sel_e sel);
    case (sel)
      GS_X1P0: gain_to_code = GAIN_W'(2);
      GS_X1P5: gain_to_code = GAIN_W'(3);
      GS_X2P5: gain_to_code = GAIN_W'(5);
      default: gain_to_code = GAIN_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] sig_i,
  output logic [NCH-1:0] lvl_o,
  output logic [NCH-1:0] rise_o
);
  logic [NCH-1:0] smp_q;
  logic [NCH-1:0] prv_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        smp_q[g] <= 1'b0;
        prv_q[g] <= 1'b0;
      end else begin
        smp_q[g] <= sig_i[g];
        prv_q[g] <= smp_q[g];
      end
    end
    assign rise_o[g] = smp_q[g] & ~prv_q[g];
  end

  assign lvl_o = smp_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int RST_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic set_up_i,
  input  logic set_dn_i,
  output logic up_o,
  output logic dn_o
);
  localparam int CNT_W = (RST_DLY < 2) ? 1 : $clog2(RST_DLY + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_DLY - 1);

  logic             up_q, dn_q;
  logic [CNT_W-1:0] cnt_q;
  logic             both, clr;

  assign both = up_q & dn_q;
  assign clr  = both & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      up_q  <= clr ? set_up_i : (up_q | set_up_i);
      dn_q  <= clr ? set_dn_i : (dn_q | set_dn_i);
      cnt_q <= (both && !clr) ? cnt_q + CNT_W'(1) : '0;
    end
  end

  assign up_o = up_q;
  assign dn_o = dn_q;
endmodule

// File: rtl/pfd_mon_route.sv
module pfd_mon_route (
  input  logic clk,
  input  logic rst,
  input  logic dir_i,
  input  logic en_i,
  input  logic rf_lvl_i,
  input  logic ref_lvl_i,
  output logic mon_a_o,
  output logic mon_b_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mon_a_o <= 1'b0;
      mon_b_o <= 1'b0;
    end else begin
      mon_a_o <= en_i & (dir_i ? rf_lvl_i  : ref_lvl_i);
      mon_b_o <= en_i & (dir_i ? ref_lvl_i : rf_lvl_i);
    end
  end
endmodule

// File: rtl/pfd_gain_dec.sv
module pfd_gain_dec
  import pfd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        sel_i,
  output logic [GAIN_W-1:0] code_o
);
  always_ff @(posedge clk) begin
    if (rst) code_o <= '0;
    else     code_o <= gain_to_code(gain_sel_e'(sel_i));
  end
endmodule

// File: rtl/pfd_dirctl.sv
module pfd_dirctl
  import pfd_pkg::*;
#(
  parameter int RST_DLY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rf_div_i,
  input  logic              ref_div_i,
  input  logic              dir_i,
  input  logic              pd_en_i,
  input  logic              mon_en_i,
  input  logic [1:0]        gain_sel_i,
  output logic              up_o,
  output logic              dn_o,
  output logic              mon_a_o,
  output logic              mon_b_o,
  output logic [GAIN_W-1:0] gain_code_o
);
  localparam int CH_RF  = 0;
  localparam int CH_REF = 1;

  logic [1:0] lvl, rise;
  logic       set_up, set_dn;

  pfd_edge_det #(.NCH(2)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_i  ({ref_div_i, rf_div_i}),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  // dir high: feedback edge leads -> sink (dn); low: reversed
  assign set_dn = dir_i ? rise[CH_RF]  : rise[CH_REF];
  assign set_up = dir_i ? rise[CH_REF] : rise[CH_RF];

  pfd_core #(.RST_DLY(RST_DLY)) u_core (
    .clk      (clk),
    .rst      (rst),
    .en_i     (pd_en_i),
    .set_up_i (set_up),
    .set_dn_i (set_dn),
    .up_o     (up_o),
    .dn_o     (dn_o)
  );

  pfd_mon_route u_mon (
    .clk       (clk),
    .rst       (rst),
    .dir_i     (dir_i),
    .en_i      (mon_en_i),
    .rf_lvl_i  (lvl[CH_RF]),
    .ref_lvl_i (lvl[CH_REF]),
    .mon_a_o   (mon_a_o),
    .mon_b_o   (mon_b_o)
  );

  pfd_gain_dec u_gain (
    .clk    (clk),
    .rst    (rst),
    .sel_i  (gain_sel_i),
    .code_o (gain_code_o)
  );
endmodule

// File: rtl/pfd_dirctl_chk.sv
module pfd_dirctl_chk #(
  parameter int RST_DLY = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       pd_en_i,
  input logic       mon_en_i,
  input logic [1:0] gain_sel_i,
  input logic       up_o,
  input logic       dn_o,
  input logic       mon_a_o,
  input logic       mon_b_o,
  input logic [3:0] gain_code_o
);
  localparam int OW = $clog2(RST_DLY + 2) + 1;
  localparam logic [OW-1:0] OMAX = {OW{1'b1}};

  logic [OW-1:0] ov_cnt;

  always_ff @(posedge clk) begin
    if (rst)                ov_cnt <= '0;
    else if (up_o && dn_o)  ov_cnt <= (ov_cnt == OMAX) ? ov_cnt : ov_cnt + OW'(1);
    else                    ov_cnt <= '0;
  end

  assert_overlap_limit_R5: assert property (@(posedge clk) disable iff (rst)
    ov_cnt <= OW'(RST_DLY));

  assert_pump_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !pd_en_i |=> (!up_o && !dn_o));

  assert_mon_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !mon_en_i |=> (!mon_a_o && !mon_b_o));

  assert_gain_min_R11: assert property (@(posedge clk) disable iff (rst)
    gain_sel_i == 2'b00 |=> gain_code_o == 4'd2);

  assert_gain_max_R11: assert property (@(posedge clk) disable iff (rst)
    gain_sel_i == 2'b11 |=> gain_code_o == 4'd8);

  assert_reset_state_R12: assert property (@(posedge clk)
    rst |=> (!up_o && !dn_o && !mon_a_o && !mon_b_o && gain_code_o == 4'd0));
endmodule

bind pfd_dirctl pfd_dirctl_chk #(.RST_DLY(RST_DLY)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pd_en_i     (pd_en_i),
  .mon_en_i    (mon_en_i),
  .gain_sel_i  (gain_sel_i),
  .up_o        (up_o),
  .dn_o        (dn_o),
  .mon_a_o     (mon_a_o),
  .mon_b_o     (mon_b_o),
  .gain_code_o (gain_code_o)
);

// File: tb/pfd_dirctl_test.sv
module pfd_dirctl_test;
  localparam int RD = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rf = 1'b0, rf_ref = 1'b0;
  logic       dir = 1'b1, pd_en = 1'b1, mon_en = 1'b1;
  logic [1:0] gsel = 2'b11;
  logic       up, dn, ma, mb;
  logic [3:0] gcode;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pfd_dirctl #(.RST_DLY(RD)) uut (
    .clk(clk), .rst(rst), .rf_div_i(rf), .ref_div_i(rf_ref),
    .dir_i(dir), .pd_en_i(pd_en), .mon_en_i(mon_en), .gain_sel_i(gsel),
    .up_o(up), .dn_o(dn), .mon_a_o(ma), .mon_b_o(mb), .gain_code_o(gcode)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one rising edge per input, at cycle t_rf and t_ref of a 40-cycle window
  task automatic run_pair(input int t_rf, input int t_ref,
                          output int nup, output int ndn, output int nboth);
    nup = 0; ndn = 0; nboth = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      nup += int'(up); ndn += int'(dn); nboth += int'(up && dn);
      rf     = (c == t_rf);
      rf_ref = (c == t_ref);
    end
    rf = 0; rf_ref = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R12 up", int'(up), 0);
    check("R12 dn", int'(dn), 0);
    check("R12 mon", int'(ma) + int'(mb), 0);
    check("R12 gain", int'(gcode), 0);
  endtask

  task automatic t_lead_lag();
    int u, d, b;
    dir = 1;
    run_pair(3, 8, u, d, b);   // feedback leads by 5
    check("R1 dn width", d, 5 + RD);
    check("R1 up width", u, RD);
    run_pair(4, 5, u, d, b);   // lead by 1
    check("R1 dn width small lead", d, 1 + RD);
    run_pair(10, 3, u, d, b);  // reference leads by 7
    check("R2 up width", u, 7 + RD);
    check("R2 dn width", d, RD);
    dir = 0;
    repeat (2) @(negedge clk);
    run_pair(3, 8, u, d, b);
    check("R3 up width", u, 5 + RD);
    check("R3 dn width", d, RD);
    run_pair(9, 3, u, d, b);
    check("R3 dn width ref lead", d, 6 + RD);
    check("R3 up width ref lead", u, RD);
    dir = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_zero_phase();
    int u, d, b;
    run_pair(5, 5, u, d, b);
    check("R4 up width", u, RD);
    check("R4 dn width", d, RD);
    check("R4 overlap", b, RD);
    check("R5 overlap bound", int'(b <= RD), 1);
  endtask

  task automatic run_freq(output int nup, output int ndn);
    nup = 0; ndn = 0;
    for (int c = 0; c < 160; c++) begin
      @(negedge clk);
      nup += int'(up); ndn += int'(dn);
      rf     = (c % 6 == 0);
      rf_ref = (c % 10 == 0);
    end
    rf = 0; rf_ref = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_freq();
    int u, d;
    dir = 1;
    run_freq(u, d);
    check("R6 dir1 dn dominates", int'(d > u), 1);
    dir = 0;
    repeat (2) @(negedge clk);
    run_freq(u, d);
    check("R6 dir0 up dominates", int'(u > d), 1);
    dir = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_disable();
    int u, d, b;
    pd_en = 0;
    run_pair(3, 9, u, d, b);
    check("R7 up idle", u, 0);
    check("R7 dn idle", d, 0);
    pd_en = 1;
    repeat (2) @(negedge clk);
    run_pair(3, 6, u, d, b);
    check("R7 resume dn", d, 3 + RD);
  endtask

  task automatic t_monitor();
    mon_en = 1; dir = 1;
    rf = 1; rf_ref = 0;
    repeat (3) @(negedge clk);
    check("R8 mon_a rf", int'(ma), 1);
    check("R8 mon_b ref", int'(mb), 0);
    rf = 0; rf_ref = 1;
    repeat (3) @(negedge clk);
    check("R8 mon_a rf low", int'(ma), 0);
    check("R8 mon_b ref high", int'(mb), 1);
    dir = 0;
    repeat (3) @(negedge clk);
    check("R9 mon_a ref", int'(ma), 1);
    check("R9 mon_b rf", int'(mb), 0);
    rf = 1; rf_ref = 1;
    mon_en = 0;
    repeat (3) @(negedge clk);
    check("R10 gated", int'(ma) + int'(mb), 0);
    mon_en = 1;
    rf = 0; rf_ref = 0; dir = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_gain();
    int exp_tab[4] = '{2, 3, 5, 8};
    for (int s = 0; s < 4; s++) begin
      gsel = 2'(s);
      repeat (2) @(negedge clk);
      check($sformatf("R11 sel %0d", s), int'(gcode), exp_tab[s]);
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    repeat (3) @(negedge clk);
    t_lead_lag();
    t_zero_phase();
    t_freq();
    t_disable();
    t_monitor();
    t_gain();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule